// File: doc/BRIEF.md
# Interrupt Request Flag Controller

This block keeps the pending-request flags of a small microcontroller and applies a separate set and clear rule to each flag. It watches three asynchronous external interrupt pins, two timer overflow strobes, a compare-event strobe and an A/D conversion-complete strobe. It drives six request lines to a downstream priority encoder. When the encoder vectors to a source, it reports that source on the acknowledge input. That acknowledge clears the flags that have a hardware-clear rule. A byte-wide register port gives software read and write access to the trigger controls and to the flags.

Each flag is a two-state machine with the states FLAG_IDLE and FLAG_PENDING. There are four transitions. A hardware set event moves FLAG_IDLE to FLAG_PENDING ("raise"). A vector acknowledge with no set in the same cycle moves FLAG_PENDING to FLAG_IDLE ("retire"), and only on flags that have a hardware-clear rule. A software write of 1 forces FLAG_PENDING ("post"). A software write of 0 forces FLAG_IDLE ("cancel"). In every other case the state holds.

The three pins pass through a two-stage synchroniser. Edges are found by comparing the synchronised sample with the sample one cycle older. External sources 0 and 1 each have a trigger-type bit that selects falling-edge or low-level operation. External source 2 has a polarity bit that selects rising or falling edges. That flag is also set by the compare strobe.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset, irq_req is 0 and both register bytes read 0, provided the pins are held high through reset.
- R2: Control byte (reg_sel=0) bit positions: 0 type-select 0, 1 ext-0 flag, 2 type-select 1, 3 ext-1 flag, 4 timer-0 run, 5 timer-0 flag, 6 timer-1 run, 7 timer-1 flag. A type-select value of 1 means falling edge and 0 means low level. The run bits are stored and read back only, and they have no effect on irq_req.
- R3: With type-select 1, a falling edge on ext0_n or ext1_n sets that flag, and the request is visible after the third rising clock edge following the pin change. A rising edge sets nothing.
- R4: With type-select 0, irq_req[0] or irq_req[2] equals the inverted pin after two rising clock edges. In that mode the stored flag is neither set by the pin nor cleared by an acknowledge.
- R5: ack_valid with ack_src codes 0 (ext 0), 1 (timer 0), 2 (ext 1), 3 (timer 1) or 4 (ext 2) clears that flag one cycle later. Codes 5 to 7 clear nothing.
- R6: A one-cycle t0_ovf or t1_ovf pulse sets irq_req[1] or irq_req[3] after the next rising edge.
- R7: The ext-2 polarity bit (aux byte bit 2) selects the edge on ext2_pin that sets the flag: 1 selects rising and 0 selects falling. The latency is the same as in R3.
- R8: cmp_evt sets the ext-2 flag in the next cycle, whatever the pin does.
- R9: adc_done sets the A/D flag (irq_req[5]). An acknowledge does not clear it, and only a software write of 0 clears it.
- R10: When a hardware set and an acknowledge of the same flag fall in the same cycle, the flag ends up set.
- R11: A software write to a flag bit overrides a hardware set or clear in the same cycle.
- R12: Aux byte (reg_sel=1) bit positions: 0 ext-2 flag, 1 A/D flag, 2 ext-2 polarity. Bits 7 to 3 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext0_n | input | 1 | External interrupt pin 0, active low |
| ext1_n | input | 1 | External interrupt pin 1, active low |
| ext2_pin | input | 1 | External interrupt pin 2, polarity selectable |
| cmp_evt | input | 1 | Compare-event strobe on the ext-2 pin |
| t0_ovf | input | 1 | Timer 0 overflow strobe |
| t1_ovf | input | 1 | Timer 1 overflow strobe |
| adc_done | input | 1 | A/D conversion-complete strobe |
| ack_valid | input | 1 | Vector acknowledge valid |
| ack_src | input | 3 | Acknowledged source code |
| reg_wr_en | input | 1 | Register write enable |
| reg_sel | input | 1 | Register select: 0 control byte, 1 aux byte |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for the selected byte |
| irq_req | output | 6 | Pending requests, indexed by source code |

## Verification
A flag stuck in the wrong state shows up on irq_req on the very next rising edge, because every request line except the level-mode ones is a direct view of a flag register. It also shows up in the readback byte in the same cycle. An edge detector or synchroniser fault appears as a request that comes one cycle too early or too late, or that comes on the wrong polarity. The bench therefore samples at exact cycle counts after each pin change. A rule-priority fault can only be seen in the cycle where two events meet. Directed collisions and long random runs with frequent overlaps of strobes, acknowledges and writes are compared cycle by cycle against a bench model.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;
    localparam int NUM_SRC = 6;
    localparam int NUM_PIN = 3;
    localparam int SRC_W   = $clog2(NUM_SRC);

    typedef enum logic [SRC_W-1:0] {
        SRC_EXT0 = 3'd0,
        SRC_TMR0 = 3'd1,
        SRC_EXT1 = 3'd2,
        SRC_TMR1 = 3'd3,
        SRC_EXT2 = 3'd4,
        SRC_ADC  = 3'd5
    } irq_src_e;

    typedef enum logic {
        FLAG_IDLE    = 1'b0,
        FLAG_PENDING = 1'b1
    } flag_state_e;

    // control byte bit positions
    localparam int CB_TYPE0 = 0;
    localparam int CB_FLAG0 = 1;
    localparam int CB_TYPE1 = 2;
    localparam int CB_FLAG1 = 3;
    localparam int CB_RUN0  = 4;
    localparam int CB_TOV0  = 5;
    localparam int CB_RUN1  = 6;
    localparam int CB_TOV1  = 7;
    // aux byte bit positions
    localparam int AB_EXT2  = 0;
    localparam int AB_ADC   = 1;
    localparam int AB_POL2  = 2;
endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
    parameter int             WIDTH   = 3,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] level_o,
    output logic [WIDTH-1:0] fall_o,
    output logic [WIDTH-1:0] rise_o
);
    logic [WIDTH-1:0] stage1_q, stage2_q, prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= RST_VAL;
            stage2_q <= RST_VAL;
            prev_q   <= RST_VAL;
        end else begin
            stage1_q <= pin_i;
            stage2_q <= stage1_q;
            prev_q   <= stage2_q;
        end
    end

    always_comb begin
        level_o = stage2_q;
        fall_o  = prev_q & ~stage2_q;
        rise_o  = ~prev_q & stage2_q;
    end

    // an edge pulse never lasts two cycles on the same pin
    assert_edge_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_o != '0) |=> ((fall_o & $past(fall_o)) == '0));
endmodule

// File: rtl/irq_flag_cell.sv
module irq_flag_cell
    import irq_flag_pkg::*;
#(
    parameter bit HW_CLEAR = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic wr_i,
    input  logic wdata_i,
    output logic pending_o
);
    flag_state_e state_q, state_d;
    logic clr_eff;

    assign clr_eff = HW_CLEAR ? clr_i : 1'b0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLAG_IDLE;
        else        state_q <= state_d;
    end

    // next state: post/cancel > raise > retire
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_IDLE: begin
                if (wr_i)       state_d = wdata_i ? FLAG_PENDING : FLAG_IDLE;
                else if (set_i) state_d = FLAG_PENDING;
            end
            FLAG_PENDING: begin
                if (wr_i)                    state_d = wdata_i ? FLAG_PENDING : FLAG_IDLE;
                else if (!set_i && clr_eff)  state_d = FLAG_IDLE;
            end
        endcase
    end

    always_comb begin
        pending_o = (state_q == FLAG_PENDING);
    end

    assert_sw_write_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (pending_o == $past(wdata_i)));
    assert_set_beats_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && !wr_i) |=> pending_o);
    assert_sw_only_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!HW_CLEAR && pending_o && !wr_i) |=> pending_o);
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
    import irq_flag_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext0_n,
    input  logic             ext1_n,
    input  logic             ext2_pin,
    input  logic             cmp_evt,
    input  logic             t0_ovf,
    input  logic             t1_ovf,
    input  logic             adc_done,
    input  logic             ack_valid,
    input  logic [SRC_W-1:0] ack_src,
    input  logic             reg_wr_en,
    input  logic             reg_sel,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    output logic [NUM_SRC-1:0] irq_req
);
    logic [NUM_PIN-1:0] pin_raw, pin_lvl, pin_fall, pin_rise;
    logic               mode0_q, mode1_q, run0_q, run1_q, pol2_q;
    logic               wr_ctrl, wr_aux;
    logic [NUM_SRC-1:0] ack_hit, set_v, clr_v, wr_v, wd_v, pend;

    assign pin_raw = {ext2_pin, ext1_n, ext0_n};

    irq_pin_sync #(.WIDTH(NUM_PIN), .RST_VAL({NUM_PIN{1'b1}})) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_i   (pin_raw),
        .level_o (pin_lvl),
        .fall_o  (pin_fall),
        .rise_o  (pin_rise)
    );

    assign wr_ctrl = reg_wr_en && !reg_sel;
    assign wr_aux  = reg_wr_en &&  reg_sel;

    // control bits that are not flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode0_q <= 1'b0;
            mode1_q <= 1'b0;
            run0_q  <= 1'b0;
            run1_q  <= 1'b0;
            pol2_q  <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                mode0_q <= reg_wdata[CB_TYPE0];
                mode1_q <= reg_wdata[CB_TYPE1];
                run0_q  <= reg_wdata[CB_RUN0];
                run1_q  <= reg_wdata[CB_RUN1];
            end
            if (wr_aux) pol2_q <= reg_wdata[AB_POL2];
        end
    end

    always_comb begin
        for (int s = 0; s < NUM_SRC; s++) ack_hit[s] = ack_valid && (ack_src == SRC_W'(s));

        set_v[SRC_EXT0] = mode0_q && pin_fall[0];
        set_v[SRC_TMR0] = t0_ovf;
        set_v[SRC_EXT1] = mode1_q && pin_fall[1];
        set_v[SRC_TMR1] = t1_ovf;
        set_v[SRC_EXT2] = (pol2_q ? pin_rise[2] : pin_fall[2]) || cmp_evt;
        set_v[SRC_ADC]  = adc_done;

        clr_v = ack_hit;
        clr_v[SRC_EXT0] = mode0_q && ack_hit[SRC_EXT0];
        clr_v[SRC_EXT1] = mode1_q && ack_hit[SRC_EXT1];

        wr_v[SRC_EXT0] = wr_ctrl;  wd_v[SRC_EXT0] = reg_wdata[CB_FLAG0];
        wr_v[SRC_TMR0] = wr_ctrl;  wd_v[SRC_TMR0] = reg_wdata[CB_TOV0];
        wr_v[SRC_EXT1] = wr_ctrl;  wd_v[SRC_EXT1] = reg_wdata[CB_FLAG1];
        wr_v[SRC_TMR1] = wr_ctrl;  wd_v[SRC_TMR1] = reg_wdata[CB_TOV1];
        wr_v[SRC_EXT2] = wr_aux;   wd_v[SRC_EXT2] = reg_wdata[AB_EXT2];
        wr_v[SRC_ADC]  = wr_aux;   wd_v[SRC_ADC]  = reg_wdata[AB_ADC];
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_flag
        irq_flag_cell #(.HW_CLEAR(g != int'(SRC_ADC))) u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .set_i     (set_v[g]),
            .clr_i     (clr_v[g]),
            .wr_i      (wr_v[g]),
            .wdata_i   (wd_v[g]),
            .pending_o (pend[g])
        );
    end

    always_comb begin
        irq_req = pend;
        irq_req[SRC_EXT0] = mode0_q ? pend[SRC_EXT0] : ~pin_lvl[0];
        irq_req[SRC_EXT1] = mode1_q ? pend[SRC_EXT1] : ~pin_lvl[1];
        if (!reg_sel)
            reg_rdata = {pend[SRC_TMR1], run1_q, pend[SRC_TMR0], run0_q,
                         pend[SRC_EXT1], mode1_q, pend[SRC_EXT0], mode0_q};
        else
            reg_rdata = {5'b0, pol2_q, pend[SRC_ADC], pend[SRC_EXT2]};
    end

    assert_level_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode0_q && ack_hit[SRC_EXT0] && !wr_ctrl) |=> $stable(pend[SRC_EXT0]));
    assert_cmp_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_evt && !wr_aux) |=> irq_req[SRC_EXT2]);
    assert_ack_retires_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_hit[SRC_TMR0] && !t0_ovf && !wr_ctrl) |=> !irq_req[SRC_TMR0]);
endmodule

// File: tb/tb_irq_flag_ctrl.sv
module tb_irq_flag_ctrl;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ext0_n = 1'b1, ext1_n = 1'b1, ext2_pin = 1'b1;
    logic cmp_evt = 0, t0_ovf = 0, t1_ovf = 0, adc_done = 0;
    logic ack_valid = 0, reg_wr_en = 0, reg_sel = 0;
    logic [2:0] ack_src = 0;
    logic [7:0] reg_wdata = 0, reg_rdata;
    logic [5:0] irq_req;

    int checks = 0, failures = 0;

    // bench model
    logic [2:0] m_s1 = 3'b111, m_s2 = 3'b111, m_prev = 3'b111;
    logic [5:0] m_flag = 0;
    logic m_mode0 = 0, m_mode1 = 0, m_run0 = 0, m_run1 = 0, m_pol = 0;

    irq_flag_ctrl dut (
        .clk(clk), .rst_n(rst_n), .ext0_n(ext0_n), .ext1_n(ext1_n), .ext2_pin(ext2_pin),
        .cmp_evt(cmp_evt), .t0_ovf(t0_ovf), .t1_ovf(t1_ovf), .adc_done(adc_done),
        .ack_valid(ack_valid), .ack_src(ack_src), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_req(irq_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic nxt(logic cur, logic wr, logic wd, logic set, logic clr);
        if (wr) return wd;
        if (set) return 1'b1;
        if (clr) return 1'b0;
        return cur;
    endfunction

    function automatic logic [5:0] exp_req();
        logic [5:0] r = m_flag;
        r[0] = m_mode0 ? m_flag[0] : ~m_s2[0];
        r[2] = m_mode1 ? m_flag[2] : ~m_s2[2-1];
        return r;
    endfunction

    function automatic logic [7:0] exp_rd(logic sel);
        if (!sel) return {m_flag[3], m_run1, m_flag[1], m_run0, m_flag[2], m_mode1, m_flag[0], m_mode0};
        return {5'b0, m_pol, m_flag[5], m_flag[4]};
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        logic [2:0] fall, rise;
        logic [5:0] hit, nf;
        logic wc, wa;
        fall = m_prev & ~m_s2;
        rise = ~m_prev & m_s2;
        for (int s = 0; s < 6; s++) hit[s] = ack_valid && (ack_src == 3'(s));
        wc = reg_wr_en && !reg_sel;
        wa = reg_wr_en && reg_sel;
        nf[0] = nxt(m_flag[0], wc, reg_wdata[1], m_mode0 && fall[0], m_mode0 && hit[0]);
        nf[1] = nxt(m_flag[1], wc, reg_wdata[5], t0_ovf, hit[1]);
        nf[2] = nxt(m_flag[2], wc, reg_wdata[3], m_mode1 && fall[1], m_mode1 && hit[2]);
        nf[3] = nxt(m_flag[3], wc, reg_wdata[7], t1_ovf, hit[3]);
        nf[4] = nxt(m_flag[4], wa, reg_wdata[0], (m_pol ? rise[2] : fall[2]) || cmp_evt, hit[4]);
        nf[5] = nxt(m_flag[5], wa, reg_wdata[1], adc_done, 1'b0);
        @(posedge clk);
        m_flag = nf;
        m_prev = m_s2; m_s2 = m_s1; m_s1 = {ext2_pin, ext1_n, ext0_n};
        if (wc) begin
            m_mode0 = reg_wdata[0]; m_mode1 = reg_wdata[2];
            m_run0 = reg_wdata[4];  m_run1 = reg_wdata[6];
        end
        if (wa) m_pol = reg_wdata[2];
        @(negedge clk);
        check("R5 R10 model irq_req", 8'(irq_req), 8'(exp_req()));
        check("R2 R12 model rdata", reg_rdata, exp_rd(reg_sel));
    endtask

    task automatic quiet();
        cmp_evt = 0; t0_ovf = 0; t1_ovf = 0; adc_done = 0;
        ack_valid = 0; reg_wr_en = 0;
    endtask

    task automatic wr(logic sel, logic [7:0] d);
        reg_wr_en = 1; reg_sel = sel; reg_wdata = d; step(); quiet();
    endtask

    task automatic ack(logic [2:0] s);
        ack_valid = 1; ack_src = s; step(); quiet();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'h1234_5678));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1 irq_req", 8'(irq_req), 8'h00);
        reg_sel = 0; #1 check("R1 ctrl byte", reg_rdata, 8'h00);
        reg_sel = 1; #1 check("R1 aux byte", reg_rdata, 8'h00);

        // R2 layout, run bits inert
        wr(0, 8'h55);
        reg_sel = 0; #1 check("R2 ctrl readback", reg_rdata, 8'h55);
        check("R2 run bits no request", 8'(irq_req), 8'h00);

        // R6 timer set, R5 ack clear
        t0_ovf = 1; step(); quiet();
        check("R6 timer0 request", 8'(irq_req), 8'h02);
        check("R2 timer0 flag bit5", reg_rdata, 8'h75);
        ack(3'd1);
        check("R5 timer0 retire", 8'(irq_req), 8'h00);

        // R3 edge latency
        ext0_n = 0; step(); step();
        check("R3 not yet after two edges", 8'(irq_req[0]), 8'h00);
        step();
        check("R3 falling edge sets ext0", 8'(irq_req), 8'h01);
        ack(3'd0);
        check("R5 ext0 retire", 8'(irq_req), 8'h00);
        ext0_n = 1; step(); step(); step();
        check("R3 rising edge ignored", 8'(irq_req), 8'h00);

        // R10 set beats ack, R11 write beats set
        t1_ovf = 1; ack_valid = 1; ack_src = 3'd3; step(); quiet();
        check("R10 set wins over ack", 8'(irq_req[3]), 8'h01);
        t1_ovf = 1; reg_wr_en = 1; reg_sel = 0; reg_wdata = 8'h55; step(); quiet();
        check("R11 write cancels over set", 8'(irq_req[3]), 8'h00);
        wr(0, 8'h57);
        check("R11 write posts ext0", 8'(irq_req), 8'h01);
        ack(3'd0);

        // R4 level mode on ext1
        wr(0, 8'h51);
        ext1_n = 0; step();
        check("R4 level not yet", 8'(irq_req[2]), 8'h00);
        step();
        check("R4 level follows pin", 8'(irq_req[2]), 8'h01);
        ack(3'd2);
        check("R4 ack no effect in level", 8'(irq_req[2]), 8'h01);
        reg_sel = 0; #1 check("R4 flag not latched", 8'(reg_rdata[3]), 8'h00);
        ext1_n = 1; step(); step();
        check("R4 level released", 8'(irq_req[2]), 8'h00);

        // R7 ext2 polarity
        wr(1, 8'h00);
        ext2_pin = 0; step(); step(); step();
        check("R7 falling polarity", 8'(irq_req[4]), 8'h01);
        ack(3'd4);
        check("R5 ext2 retire", 8'(irq_req[4]), 8'h00);
        wr(1, 8'h04);
        ext2_pin = 1; step(); step(); step();
        check("R7 rising polarity", 8'(irq_req[4]), 8'h01);
        reg_sel = 1; #1 check("R12 aux readback", reg_rdata, 8'h05);
        ack(3'd4);

        // R8 compare event
        cmp_evt = 1; step(); quiet();
        check("R8 compare sets ext2", 8'(irq_req[4]), 8'h01);
        ack(3'd4);

        // R9 adc software-only clear
        adc_done = 1; step(); quiet();
        check("R9 adc sets", 8'(irq_req[5]), 8'h01);
        ack(3'd5);
        check("R9 ack keeps adc", 8'(irq_req[5]), 8'h01);
        wr(1, 8'h04);
        check("R9 write clears adc", 8'(irq_req[5]), 8'h00);

        // random phase
        for (int i = 0; i < 6000; i++) begin
            if ($urandom_range(7) == 0) ext0_n = ~ext0_n;
            if ($urandom_range(7) == 0) ext1_n = ~ext1_n;
            if ($urandom_range(7) == 0) ext2_pin = ~ext2_pin;
            cmp_evt  = ($urandom_range(9) == 0);
            t0_ovf   = ($urandom_range(9) == 0);
            t1_ovf   = ($urandom_range(9) == 0);
            adc_done = ($urandom_range(9) == 0);
            ack_valid = ($urandom_range(3) == 0);
            ack_src   = 3'($urandom_range(7));
            reg_wr_en = ($urandom_range(15) == 0);
            reg_sel   = 1'($urandom_range(1));
            reg_wdata = 8'($urandom_range(255));
            step();
        end
        quiet();
        step();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule